// File: doc/BRIEF.md
# Predicate Flag Store and Condition Gate

This block decides, for every instruction, whether it may take effect. A compare request evaluates two signed operands, or one operand against a sign-extended short immediate. The result is kept in a small flag store: an "equal" bit and a "signed less-than" bit. Any instruction may carry a 3-bit predicate that is tested against these stored flags. The result is an execute-enable that the rest of the pipeline uses to allow or suppress register writes, memory writes and stack changes.

Branches use a second, direct path. A branch request compares its own two operands according to a branch kind. The branch is taken only when that comparison holds and the branch's own predicate also passes. The execute-enable and the branch decision are combinational in the cycle the request is presented. A compare that executes updates the flag store at the next clock edge, so the following instruction sees the new result.

Top module: `pred_flag_unit`

## Requirements
- R1: After reset the store reads as equal and not less, so predicates eq, ge and le execute and ne, lt and gt do not.
- R2: A compare request whose predicate passes loads equal = (A == B) and less = signed(A) < signed(B), where A is cmpOpA and B is the selected compare operand.
- R3: With cmpUseImm high, the compare operand B is cmpImm sign-extended from 12 bits to the data width, and cmpOpB is ignored.
- R4: The predicate codes are 0 none (always), 1 eq, 2 ne, 3 lt, 4 ge (not less), 5 gt (neither equal nor less) and 6 le (less or equal). Each is tested against the stored flags.
- R5: Predicate code 7 is reserved. execEn is low and the flags and brTaken are unaffected.
- R6: The stored flags keep their value on any cycle without an executing compare, including cycles with branch requests.
- R7: A compare whose own predicate fails leaves the stored flags unchanged.
- R8: brTaken follows a signed direct compare of brOpA against brOpB. The brKind encodings are 0 eq, 1 ne, 2 lt, 3 le, 4 gt and 5 ge. Kinds 6 and 7 are never taken.
- R9: brTaken is high only when brReq is high, the predicate passes, and the direct compare of R8 holds. The stored flags have no other influence on it.
- R10: execEn reflects the flags stored before the current cycle. A compare is first visible to the instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| condCode | input | 3 | Predicate of the current instruction |
| cmpReq | input | 1 | Current instruction is a compare |
| cmpUseImm | input | 1 | Compare against the immediate instead of cmpOpB |
| cmpOpA | input | DATA_W | Compare left operand |
| cmpOpB | input | DATA_W | Compare right register operand |
| cmpImm | input | IMM_W | Compare immediate, sign-extended |
| brReq | input | 1 | Current instruction is a conditional branch |
| brKind | input | 3 | Branch comparison kind |
| brOpA | input | DATA_W | Branch left operand |
| brOpB | input | DATA_W | Branch right operand |
| execEn | output | 1 | Predicate passes; instruction may take effect |
| brTaken | output | 1 | Branch is taken |

## Verification
The bench builds the block at its default widths: 32-bit data and a 12-bit immediate. These widths bring the sign boundaries into reach: the most negative against the most positive data value, and the immediates -2048, -1 and 2047, where an unsigned or zero-extending compare would give the opposite answer. Each stored flag combination is reached, and every predicate code is swept against it. Branches are run against stored flags that disagree with their own operands.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [2:0] {
    CondNone = 3'd0,
    CondEq   = 3'd1,
    CondNe   = 3'd2,
    CondLt   = 3'd3,
    CondGe   = 3'd4,
    CondGt   = 3'd5,
    CondLe   = 3'd6,
    CondRsvd = 3'd7
  } condCode_e;

  typedef enum logic [2:0] {
    BrEq   = 3'd0,
    BrNe   = 3'd1,
    BrLt   = 3'd2,
    BrLe   = 3'd3,
    BrGt   = 3'd4,
    BrGe   = 3'd5,
    BrRsv6 = 3'd6,
    BrRsv7 = 3'd7
  } brKind_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic flagLoad;   // capture compare outcome this edge
    logic brGate;     // branch request whose predicate passed
  } ctrlStrobes_t;

endpackage

// File: rtl/pred_cmp.sv
module pred_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              isEq,
  output logic              isLt
);
  always_comb begin
    isEq = (lhs == rhs);
    isLt = ($signed(lhs) < $signed(rhs));
  end
endmodule

// File: rtl/pred_dpath.sv
module pred_dpath
  import pred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              cmpUseImm,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic [IMM_W-1:0]  cmpImm,
  input  logic [2:0]        brKind,
  input  logic [DATA_W-1:0] brOpA,
  input  logic [DATA_W-1:0] brOpB,
  output logic              eqFlag,
  output logic              ltFlag,
  output logic              brTaken
);
  localparam int EXT_W  = DATA_W - IMM_W;
  localparam int N_CMP  = 2;
  localparam int CMP_IX = 0;
  localparam int BR_IX  = 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] lhs [N_CMP];
  logic [DATA_W-1:0] rhs [N_CMP];
  logic              cEq [N_CMP];
  logic              cLt [N_CMP];
  logic              brHit;

  assign immExt = {{EXT_W{cmpImm[IMM_W-1]}}, cmpImm};

  always_comb begin
    lhs[CMP_IX] = cmpOpA;
    rhs[CMP_IX] = cmpUseImm ? immExt : cmpOpB;
    lhs[BR_IX]  = brOpA;
    rhs[BR_IX]  = brOpB;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    pred_cmp #(.DATA_W(DATA_W)) cmp_i (
      .lhs  (lhs[g]),
      .rhs  (rhs[g]),
      .isEq (cEq[g]),
      .isLt (cLt[g])
    );
  end

  // Flag store: reset reads as "equal"
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eqFlag <= 1'b1;
      ltFlag <= 1'b0;
    end else if (strb.flagLoad) begin
      eqFlag <= cEq[CMP_IX];
      ltFlag <= cLt[CMP_IX];
    end
  end

  always_comb begin
    unique case (brKind_e'(brKind))
      BrEq:    brHit = cEq[BR_IX];
      BrNe:    brHit = !cEq[BR_IX];
      BrLt:    brHit = cLt[BR_IX];
      BrLe:    brHit = cLt[BR_IX] || cEq[BR_IX];
      BrGt:    brHit = !cLt[BR_IX] && !cEq[BR_IX];
      BrGe:    brHit = !cLt[BR_IX];
      default: brHit = 1'b0;
    endcase
  end

  assign brTaken = strb.brGate && brHit;

  // R6: no load strobe, no change
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flagLoad |=> $stable({eqFlag, ltFlag}));

  // R2: equal and less are never both set
  p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eqFlag, ltFlag}));

  // R8: reserved kinds never taken
  p_br_rsvd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brKind[2:1] == 2'b11) |-> !brTaken);
endmodule

// File: rtl/pred_ctrl.sv
module pred_ctrl
  import pred_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   condCode,
  input  logic         cmpReq,
  input  logic         brReq,
  input  logic         eqFlag,
  input  logic         ltFlag,
  output logic         execEn,
  output ctrlStrobes_t strb
);
  logic condPass;

  always_comb begin
    unique case (condCode_e'(condCode))
      CondNone: condPass = 1'b1;
      CondEq:   condPass = eqFlag;
      CondNe:   condPass = !eqFlag;
      CondLt:   condPass = ltFlag;
      CondGe:   condPass = !ltFlag;
      CondGt:   condPass = !ltFlag && !eqFlag;
      CondLe:   condPass = ltFlag || eqFlag;
      default:  condPass = 1'b0;
    endcase
  end

  assign execEn        = condPass;
  assign strb.flagLoad = cmpReq && condPass;
  assign strb.brGate   = brReq && condPass;

  // R5: reserved predicate never executes
  p_cond_rsvd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 3'd7) |-> (!execEn && !strb.flagLoad && !strb.brGate));

  // R7: failed predicate never loads the flags
  p_no_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |-> !strb.flagLoad);

  // R4: code none always passes
  p_cond_none_r4: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 3'd0) |-> execEn);
endmodule

// File: rtl/pred_flag_unit.sv
module pred_flag_unit
  import pred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        condCode,
  input  logic              cmpReq,
  input  logic              cmpUseImm,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic [IMM_W-1:0]  cmpImm,
  input  logic              brReq,
  input  logic [2:0]        brKind,
  input  logic [DATA_W-1:0] brOpA,
  input  logic [DATA_W-1:0] brOpB,
  output logic              execEn,
  output logic              brTaken
);
  ctrlStrobes_t strb;
  logic         eqFlag;
  logic         ltFlag;

  pred_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .condCode (condCode),
    .cmpReq   (cmpReq),
    .brReq    (brReq),
    .eqFlag   (eqFlag),
    .ltFlag   (ltFlag),
    .execEn   (execEn),
    .strb     (strb)
  );

  pred_dpath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpUseImm (cmpUseImm),
    .cmpOpA    (cmpOpA),
    .cmpOpB    (cmpOpB),
    .cmpImm    (cmpImm),
    .brKind    (brKind),
    .brOpA     (brOpA),
    .brOpB     (brOpB),
    .eqFlag    (eqFlag),
    .ltFlag    (ltFlag),
    .brTaken   (brTaken)
  );

  // R9: a taken branch needs both the request and a passing predicate
  p_br_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> (brReq && execEn));
endmodule

// File: tb/pred_flag_unit_tb_top.sv
module pred_flag_unit_tb_top;
  localparam int DW = 32;
  localparam int IW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    condCode = '0;
  logic          cmpReq = 1'b0;
  logic          cmpUseImm = 1'b0;
  logic [DW-1:0] cmpOpA = '0;
  logic [DW-1:0] cmpOpB = '0;
  logic [IW-1:0] cmpImm = '0;
  logic          brReq = 1'b0;
  logic [2:0]    brKind = '0;
  logic [DW-1:0] brOpA = '0;
  logic [DW-1:0] brOpB = '0;
  logic          execEn;
  logic          brTaken;

  int checks = 0;
  int fails  = 0;
  bit refEq  = 1'b1;
  bit refLt  = 1'b0;

  always #2.5 clk = ~clk;

  pred_flag_unit #(.DATA_W(DW), .IMM_W(IW)) dut_i (.*);

  function automatic bit condOk(input int c, input bit e, input bit l);
    case (c)
      0: return 1'b1;
      1: return e;
      2: return !e;
      3: return l;
      4: return !l;
      5: return !l && !e;
      6: return l || e;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit brOk(input int k, input logic [DW-1:0] a, input logic [DW-1:0] b);
    bit e = (a == b);
    bit l = ($signed(a) < $signed(b));
    case (k)
      0: return e;
      1: return !e;
      2: return l;
      3: return l || e;
      4: return !l && !e;
      5: return !l;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One instruction cycle: drive at negedge, check before posedge, update model
  task automatic issue(input string req, input int c, input bit isCmp, input bit useImm,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [IW-1:0] imm,
                       input bit isBr, input int k, input logic [DW-1:0] ba, input logic [DW-1:0] bb);
    logic [DW-1:0] rhsV;
    bit pass;
    @(negedge clk);
    condCode = 3'(c); cmpReq = isCmp; cmpUseImm = useImm; cmpOpA = a; cmpOpB = b;
    cmpImm = imm; brReq = isBr; brKind = 3'(k); brOpA = ba; brOpB = bb;
    #1;
    pass = condOk(c, refEq, refLt);
    check(req, execEn, pass);
    check(req, brTaken, isBr && pass && brOk(k, ba, bb));
    rhsV = useImm ? {{(DW-IW){imm[IW-1]}}, imm} : b;
    if (isCmp && pass) begin
      refEq = (a == rhsV);
      refLt = ($signed(a) < $signed(rhsV));
    end
  endtask

  task automatic cmpReg(input string req, input int c, input logic [DW-1:0] a, input logic [DW-1:0] b);
    issue(req, c, 1, 0, a, b, '0, 0, 0, '0, '0);
  endtask

  task automatic cmpImmOp(input string req, input logic [DW-1:0] a, input logic [IW-1:0] imm,
                          input logic [DW-1:0] junkB);
    issue(req, 0, 1, 1, a, junkB, imm, 0, 0, '0, '0);
  endtask

  task automatic sweepConds(input string req);
    for (int c = 0; c < 8; c++) issue(req, c, 0, 0, '0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic tReset();
    sweepConds("R1");
  endtask

  task automatic tRegCompare();
    cmpReg("R2", 0, 32'd5, 32'd9);            sweepConds("R2 R4");
    cmpReg("R2", 0, 32'h8000_0000, 32'h7FFF_FFFF); sweepConds("R2 R4");
    cmpReg("R2", 0, 32'h7FFF_FFFF, 32'h8000_0000); sweepConds("R2 R4");
    cmpReg("R2", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); sweepConds("R2 R4");
  endtask

  task automatic tImmCompare();
    cmpImmOp("R3", 32'hFFFF_F800, 12'h800, 32'h0);  sweepConds("R3");
    cmpImmOp("R3", 32'd0, 12'hFFF, 32'h0);          sweepConds("R3");
    cmpImmOp("R3", 32'd2047, 12'h7FF, 32'd5);       sweepConds("R3");
    cmpImmOp("R3", 32'd4095, 12'hFFF, 32'd4095);    sweepConds("R3");
  endtask

  task automatic tReserved();
    cmpReg("R5", 0, 32'd3, 32'd3);
    issue("R5", 7, 1, 0, 32'd1, 32'd2, '0, 1, 0, 32'd4, 32'd4);
    sweepConds("R5");
  endtask

  task automatic tHold();
    cmpReg("R6", 0, 32'd10, 32'd2);
    for (int i = 0; i < 5; i++) issue("R6", 0, 0, 0, 32'd1, 32'd9, '0, 1, i, 32'd1, 32'd9);
    sweepConds("R6");
  endtask

  task automatic tPredCompare();
    cmpReg("R7", 0, 32'd7, 32'd7);
    cmpReg("R7", 2, 32'd1, 32'd9);   // ne fails: no load
    sweepConds("R7");
    cmpReg("R7", 1, 32'd1, 32'd9);   // eq passes: loads lt
    sweepConds("R7");
  endtask

  task automatic tBranch();
    logic [DW-1:0] va [4] = '{32'd3, 32'hFFFF_FFFE, 32'h8000_0000, 32'd3};
    logic [DW-1:0] vb [4] = '{32'd3, 32'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
    cmpReg("R8", 0, 32'd0, 32'd0);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++) issue("R8", 0, 0, 0, '0, '0, '0, 1, k, va[p], vb[p]);
  endtask

  task automatic tBranchPred();
    cmpReg("R9", 0, 32'd1, 32'd2);   // stored lt
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 6; k++) issue("R9", c, 0, 0, '0, '0, '0, 1, k, 32'd9, 32'd9);
    issue("R9", 0, 0, 0, '0, '0, '0, 0, 0, 32'd9, 32'd9);
  endtask

  task automatic tVisibility();
    cmpReg("R10", 0, 32'd4, 32'd4);
    cmpReg("R10", 1, 32'd8, 32'd1);  // eq uses old (equal) flags
    issue("R10", 1, 0, 0, '0, '0, '0, 0, 0, '0, '0); // now gt: eq fails
    issue("R10", 5, 0, 0, '0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRegCompare();
    tImmCompare();
    tReserved();
    tHold();
    tPredCompare();
    tBranch();
    tBranchPred();
    tVisibility();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule